// File: doc/BRIEF.md
# Timer-Driven Serial ADC Reader

This block runs a three-wire link to a serial analog-to-digital converter. The wires are an active-low chip select that frames each transfer, a serial clock that the block generates, and a serial data line that the block reads. The serial clock comes from the system clock through a programmable half-period divider. A free-running interval timer fires at a programmable period. Each time it fires while the link is idle, a new conversion frame starts, so samples are evenly spaced in time.

A normal frame lasts 24 serial clock cycles. The converter returns 4 zero bits, then a 16-bit result with the most significant bit first, then 4 zero bits. The first zero is already on the data line when chip select falls, so the block samples on rising serial clock edges and the first rising edge already returns frame bit 1. Once chip select rises, the block presents only the 16 result bits, together with a one-cycle valid strobe. A power-down request is latched. At the next timer firing it is sent as a short frame of 8 serial clock cycles, which yields no result.

Top module: `serial_adc_reader`

## Requirements
- R1: While `rst` is high and in the cycle after it, `cs_n` and `sclk` are 1, and `data_valid` and `data_out` are 0.
- R2: While `cs_n` is low, `sclk` holds each level for exactly `half_div`+1 system clock cycles. This includes the first half period, which starts when `cs_n` falls.
- R3: The interval timer fires every `interval`+1 system clock cycles. When the link is idle at a firing, `cs_n` falls, so when frames are not held off they start `interval`+1 cycles apart.
- R4: A normal frame has exactly 24 falling `sclk` edges while `cs_n` is low. `sclk` is high whenever `cs_n` is high and at every `cs_n` transition.
- R5: `sdata` is sampled on each rising `sclk` edge, and rising edge k returns frame bit k. Frame bit 0 is present when `cs_n` falls. `data_out` is frame bits 4 to 19, with bit 4 as the MSB. `data_out` changes only with a valid strobe.
- R6: `data_valid` is a single-cycle pulse. It coincides with `cs_n` rising after a normal frame, and there is one pulse per normal frame.
- R7: After a `pd_req` pulse, the next frame has exactly 8 falling `sclk` edges. That frame gives no `data_valid` pulse and leaves `data_out` unchanged.
- R8: The frame after a power-down frame is a normal 24-cycle frame that delivers a fresh result.
- R9: Between frames, `cs_n` stays high for at least one full `sclk` period (2·(`half_div`+1) cycles). A timer firing that arrives while a frame or this gap is in progress starts no frame.
- R10: A synchronous reset drops a pending power-down request, so the first frame after reset is a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| interval | input | TMR_W | Sample timer period minus one, in system clocks |
| pd_req | input | 1 | Pulse that requests a power-down frame |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select and frame sync |
| sclk | output | 1 | Serial clock, idles high |
| data_out | output | DW | Last extracted result |
| data_valid | output | 1 | One-cycle strobe for a new result |

## Verification
The hardest situation to reach is the exchange of a normal frame for a power-down frame. The request has to be latched while the link is busy or idle, and consumed only at the next timer firing. The bench pulses the request just after a valid result, checks that the following frame is the 8-cycle truncated one with no strobe and an unchanged result, and then checks that the next frame returns to a full result. A second case raises the request and resets before any firing, to show that the request is dropped. A short timer period forces firings to land during frames, which exercises the rule that busy-time firings are skipped.

// File: rtl/serial_adc_reader.sv
module serial_adc_reader #(
  parameter int DW     = 16,
  parameter int LEAD   = 4,
  parameter int TRAIL  = 4,
  parameter int PD_CYC = 8,
  parameter int DIV_W  = 8,
  parameter int TMR_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_div,
  input  logic [TMR_W-1:0] interval,
  input  logic             pd_req,
  input  logic             sdata,
  output logic             cs_n,
  output logic             sclk,
  output logic [DW-1:0]    data_out,
  output logic             data_valid
);
  localparam int FRAME = LEAD + DW + TRAIL;
  localparam int SRW   = FRAME - LEAD + 1;
  localparam int EC_W  = $clog2(FRAME + 1);

  typedef enum logic [1:0] {IDLE, RUN, GAP} st_t;
  st_t st;

  logic [TMR_W-1:0] tmr;
  logic [DIV_W-1:0] hc;
  logic [EC_W-1:0]  ec;
  logic [SRW-1:0]   sr;
  logic             pend, pd_frame;

  wire tick   = (tmr == interval);
  wire expire = (hc == half_div);
  wire [EC_W-1:0] ec_lim = pd_frame ? EC_W'(PD_CYC) : EC_W'(FRAME);

  always_ff @(posedge clk) begin
    if (rst || tick) tmr <= '0;
    else             tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE; cs_n <= 1'b1; sclk <= 1'b1; hc <= '0; ec <= '0;
      pend <= 1'b0; pd_frame <= 1'b0; sr <= '0;
      data_out <= '0; data_valid <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      if (pd_req) pend <= 1'b1;
      case (st)
        IDLE: if (tick) begin
          st <= RUN; cs_n <= 1'b0; hc <= '0; ec <= '0;
          pd_frame <= pend; pend <= pd_req;
        end
        RUN: if (!expire) hc <= hc + 1'b1;
        else begin
          hc <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            ec   <= ec + 1'b1;
            sr   <= {sr[SRW-2:0], sdata};
          end else if (ec == ec_lim) begin
            cs_n <= 1'b1; st <= GAP; ec <= '0;
            if (!pd_frame) begin
              data_out   <= sr[SRW-1 -: DW];
              data_valid <= 1'b1;
            end
          end else sclk <= 1'b0;
        end
        GAP: if (!expire) hc <= hc + 1'b1;
        else begin
          hc <= '0;
          if (ec == EC_W'(1)) st <= IDLE;
          else                ec <= ec + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module serial_adc_reader_chk #(parameter int DW = 16) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          sclk,
  input logic [DW-1:0] data_out,
  input logic          data_valid
);
  p_sclk_idle_high_r4: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);
  p_cs_edge_sclk_high_r4: assert property (@(posedge clk) disable iff (rst)
    (cs_n != $past(cs_n)) |-> (sclk && $past(sclk)));
  p_valid_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);
  p_valid_on_cs_rise_r6: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (cs_n && !$past(cs_n)));
  p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !data_valid |-> $stable(data_out));
  p_sclk_quiet_gap_r9: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> $stable(sclk));
endmodule

bind serial_adc_reader serial_adc_reader_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
  .data_out(data_out), .data_valid(data_valid));

// File: tb/tb_serial_adc_reader.sv
module tb_serial_adc_reader;
  logic clk = 1'b0, rst = 1'b1, pd_req = 1'b0, sdata = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic [15:0] interval = 16'd120;
  logic cs_n, sclk, data_valid;
  logic [15:0] data_out;

  serial_adc_reader dut (
    .clk(clk), .rst(rst), .half_div(half_div), .interval(interval),
    .pd_req(pd_req), .sdata(sdata), .cs_n(cs_n), .sclk(sclk),
    .data_out(data_out), .data_valid(data_valid));

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  logic [15:0] word = 16'h0;

  // monitor and converter model
  int cyc = 0, idx = 0, edges = 0, last_edges = 0, frames_done = 0, nfall = 0;
  int last_tog = 0, last_fall = 0, last_rise = 0, spacing = 0, min_gap = 1 << 30;
  int hmin = 1 << 30, hmax = 0, valid_cnt = 0;
  logic [15:0] last_data = 16'h0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_valid = 1'b0, vbad = 1'b0;

  function automatic logic fbit(int i, logic [15:0] w);
    return (i >= 4 && i < 20) ? w[19-i] : 1'b0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      idx = 0; edges = 0; last_edges = 0; frames_done = 0; nfall = 0;
      spacing = 0; min_gap = 1 << 30; hmin = 1 << 30; hmax = 0;
      valid_cnt = 0; vbad = 1'b0; sdata = 1'b0;
      prev_cs = 1'b1; prev_sclk = 1'b1; prev_valid = 1'b0;
    end else begin
      if (prev_cs && !cs_n) begin
        idx = 0; sdata = fbit(0, word); edges = 0; last_tog = cyc;
        if (nfall > 0) spacing = cyc - last_fall;
        if (frames_done > 0 && cyc - last_rise < min_gap) min_gap = cyc - last_rise;
        last_fall = cyc; nfall++;
      end
      if (!cs_n && sclk != prev_sclk) begin
        if (cyc - last_tog < hmin) hmin = cyc - last_tog;
        if (cyc - last_tog > hmax) hmax = cyc - last_tog;
        last_tog = cyc;
      end
      if (!cs_n && prev_sclk && !sclk) begin
        edges++; idx++; sdata = fbit(idx, word);
      end
      if (!prev_cs && cs_n) begin
        frames_done++; last_edges = edges; last_rise = cyc;
      end
      if (data_valid) begin
        valid_cnt++; last_data = data_out;
        if (prev_valid) vbad = 1'b1;
      end
      prev_cs = cs_n; prev_sclk = sclk; prev_valid = data_valid;
    end
  end

  task automatic chk(string req, logic ok, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_frames(int n);
    while (frames_done < n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // {half_div[3:0], interval[15:0], word[15:0]}
  localparam logic [35:0] VEC [4] = '{
    {4'd0, 16'd60,  16'hA5C3},
    {4'd1, 16'd120, 16'h8001},
    {4'd2, 16'd200, 16'h7FFE},
    {4'd3, 16'd250, 16'hFFFF}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", cs_n == 1'b1, cs_n, 1);
    chk("R1 reset sclk", sclk == 1'b1, sclk, 1);
    chk("R1 reset valid", data_valid == 1'b0, data_valid, 0);
    chk("R1 reset data", data_out == 16'h0, data_out, 0);
    rst = 1'b0;

    for (int v = 0; v < 4; v++) begin
      half_div = 8'(VEC[v][35:32]);
      interval = VEC[v][31:16];
      word     = VEC[v][15:0];
      do_reset();
      wait_frames(2);
      @(negedge clk);
      chk("R2 half period min", hmin == int'(half_div) + 1, hmin, int'(half_div) + 1);
      chk("R2 half period max", hmax == int'(half_div) + 1, hmax, int'(half_div) + 1);
      chk("R3 frame spacing", spacing == int'(interval) + 1, spacing, int'(interval) + 1);
      chk("R4 frame length", last_edges == 24, last_edges, 24);
      chk("R5 result", last_data == word, last_data, word);
      chk("R6 valid count", valid_cnt == 2, valid_cnt, 2);
      chk("R6 valid width", !vbad, vbad, 0);
      chk("R9 min gap", min_gap >= 2 * (int'(half_div) + 1), min_gap, 2 * (int'(half_div) + 1));
    end

    // R7/R8: power-down frame then normal frame
    half_div = 8'd1; interval = 16'd120; word = 16'h5A3C;
    do_reset();
    wait_frames(1);
    @(negedge clk); pd_req = 1'b1; @(negedge clk); pd_req = 1'b0;
    word = 16'hC0DE;
    wait_frames(2);
    repeat (2) @(negedge clk);
    chk("R7 pd frame length", last_edges == 8, last_edges, 8);
    chk("R7 no valid on pd", valid_cnt == 1, valid_cnt, 1);
    chk("R7 data unchanged", data_out == 16'h5A3C, data_out, 16'h5A3C);
    wait_frames(3);
    @(negedge clk);
    chk("R8 normal after pd", last_edges == 24, last_edges, 24);
    chk("R8 fresh result", last_data == 16'hC0DE, last_data, 16'hC0DE);
    chk("R8 valid count", valid_cnt == 2, valid_cnt, 2);

    // R10/R1: reset drops pending request and clears result
    @(negedge clk); pd_req = 1'b1; @(negedge clk); pd_req = 1'b0;
    word = 16'h1234;
    do_reset();
    @(negedge clk);
    chk("R1 data cleared by reset", data_out == 16'h0, data_out, 0);
    wait_frames(1);
    @(negedge clk);
    chk("R10 full frame after reset", last_edges == 24, last_edges, 24);
    chk("R10 result after reset", last_data == 16'h1234, last_data, 16'h1234);

    // R9: short timer period, firings land during busy time
    half_div = 8'd1; interval = 16'd10; word = 16'h0F0F;
    do_reset();
    wait_frames(3);
    @(negedge clk);
    chk("R9 frame length with skipped firings", last_edges == 24, last_edges, 24);
    chk("R9 min gap short interval", min_gap >= 4, min_gap, 4);
    chk("R9 valid count", valid_cnt == 3, valid_cnt, 3);
    chk("R9 result", last_data == 16'h0F0F, last_data, 16'h0F0F);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule